// File: doc/BRIEF.md
# Paired-Channel Coincidence Trigger Qualifier

This block qualifies triggers for two coupled acquisition channels, an even channel and an odd channel. Each channel takes a raw self-trigger pulse and opens a shaped trigger window whose length is a programmable count of clock ticks. The two windows are merged into one pair-level shaped trigger according to a selectable combination code. Each channel runs in one of two modes. In independent mode every enabled hit is accepted. In coincidence mode a hit is accepted only while a selected validation source is active. That source can be the partner's window, an external validation line that stands for a board-level mask result, or the pair combination.

The block is used inside a digitizer front end. Pulse detection sits upstream and drives the raw inputs. The configuration arrives on static ports. The per-channel accept strobes and the pair-level trigger-out feed the readout and trigger distribution logic. Configuration is held in a shadow register while any window is open, so an open window is never cut short by a change. Both accept strobes and the trigger-out are registered and appear one cycle after the cycle that qualified them.

Top module: `pair_coinc_trigger`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, acc_even, acc_odd and trig_out are low and no window is open.
- R2: An enabled hit in cycle c opens that channel's window for cycles c through c+W, where W is the width field (value 0x7D gives 125 ticks after the hit). A new hit while the window is open restarts it at c'+W. The new hit does not add its width to the time that remains.
- R3: When a channel's self-trigger-off bit is 1, its raw input is ignored. It opens no window, causes no accept, and adds nothing to the partner's validation or to trig_out.
- R4: In mode code 00 (independent), every enabled hit in cycle c gives a one-cycle acc pulse in cycle c+1.
- R5: In mode code 01 (coincidence), a hit is accepted once, at the first cycle inside its own window where the channel's validation is true. The acc pulse follows one cycle later. If validation never comes before the window closes, there is no accept.
- R6: The 3-bit validation select works as follows: 000 uses the partner's window; 001 uses the partner's window OR ext_valid; 010 uses the partner's window AND ext_valid; 011 uses the pair combination; 101 uses ext_valid alone.
- R7: The 3-bit pair combination code works as follows: 000 gives AND of both windows; 001 gives OR; 101 gives the even window only; 110 gives the odd window only. trig_out is a one-cycle pulse in the cycle after the combination goes from false to true.
- R8: With both channels in coincidence mode and validating on the partner, both channels are accepted when their hits lie W or fewer cycles apart. Neither channel is accepted when the hits lie W+1 or more cycles apart.
- R9: The configuration inputs take effect only in cycles where neither window is open from an earlier hit. While a window is open, the values captured at the last idle cycle stay in force.
- R10: Mode codes 10 and 11 never produce an accept. Validation codes and combination codes that are not listed above evaluate to false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_even | input | 1 | Raw self-trigger, even channel |
| raw_odd | input | 1 | Raw self-trigger, odd channel |
| ext_valid | input | 1 | External validation (board mask result) |
| cfg_mode_even | input | 2 | Even channel mode: 00 independent, 01 coincidence |
| cfg_mode_odd | input | 2 | Odd channel mode |
| cfg_self_off_even | input | 1 | Ignore even raw trigger |
| cfg_self_off_odd | input | 1 | Ignore odd raw trigger |
| cfg_width_even | input | WIDTH_W | Even window length in ticks after the hit |
| cfg_width_odd | input | WIDTH_W | Odd window length in ticks after the hit |
| cfg_val_even | input | 3 | Even validation source select |
| cfg_val_odd | input | 3 | Odd validation source select |
| cfg_pair_mode | input | 3 | Pair combination code |
| acc_even | output | 1 | Even accept strobe |
| acc_odd | output | 1 | Odd accept strobe |
| trig_out | output | 1 | Pair-level trigger pulse |

## Verification
The hardest case to reach is a configuration change that lands while a window is open. A wrong design applies it at once, and only the later fate of a hit reveals the difference. The stimulus opens the even window, then changes the odd mode, the widths and the validation select mid-window. It fires an odd hit that must still be judged under the old settings, and then repeats the same pattern after an idle gap, where the new settings must apply. The window edges are checked by placing partner hits exactly W and W+1 cycles apart, both after a single hit and after a restarted window. This separates a restarted window from an additive one.

// File: rtl/pct_pkg.sv
package pct_pkg;
   // channel mode codes
   localparam logic [1:0] TM_NORMAL = 2'b00;
   localparam logic [1:0] TM_COINC  = 2'b01;

   // pair combination codes
   localparam logic [2:0] PC_AND  = 3'b000;
   localparam logic [2:0] PC_OR   = 3'b001;
   localparam logic [2:0] PC_EVEN = 3'b101;
   localparam logic [2:0] PC_ODD  = 3'b110;

   // validation source codes
   localparam logic [2:0] VS_PARTNER = 3'b000;
   localparam logic [2:0] VS_ANY     = 3'b001;
   localparam logic [2:0] VS_BOTH    = 3'b010;
   localparam logic [2:0] VS_PAIR    = 3'b011;
   localparam logic [2:0] VS_EXT     = 3'b101;

   localparam int MODE_BITS = 2;
   localparam int SEL_BITS  = 3;

   function automatic int ch_bits(input int width_w);
      return MODE_BITS + 1 + SEL_BITS + width_w;
   endfunction
endpackage

// File: rtl/pct_cfg_hold.sv
module pct_cfg_hold #(
   parameter int CFG_BITS = 35
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                idle,
   input  logic [CFG_BITS-1:0] cfg_in,
   output logic [CFG_BITS-1:0] cfg_eff
);
   logic [CFG_BITS-1:0] held_q;

   // live inputs pass through only while no window is open
   assign cfg_eff = idle ? cfg_in : held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) held_q <= '0;
      else        held_q <= cfg_eff;
   end
endmodule

// File: rtl/pct_window.sv
module pct_window
   import pct_pkg::*;
#(
   parameter int WIDTH_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               raw,
   input  logic               self_off,
   input  logic [1:0]         mode,
   input  logic [WIDTH_W-1:0] width,
   input  logic               val,
   output logic               hit,
   output logic               open_now,
   output logic               qual,
   output logic [WIDTH_W-1:0] cnt
);
   logic pend_q;
   logic live;
   logic armed;

   assign hit      = raw & ~self_off;
   assign live     = (cnt != '0);
   assign open_now = hit | live;
   assign armed    = hit | (pend_q & live);

   always_comb begin
      case (mode)
         TM_NORMAL: qual = hit;
         TM_COINC:  qual = armed & val;
         default:   qual = 1'b0;
      endcase
   end

   // restart on hit, count down otherwise
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         pend_q <= 1'b0;
      end else begin
         if (hit)       cnt <= width;
         else if (live) cnt <= cnt - 1'b1;
         pend_q <= (mode == TM_COINC) & armed & ~qual;
      end
   end
endmodule

// File: rtl/pct_val_sel.sv
module pct_val_sel
   import pct_pkg::*;
(
   input  logic [2:0] sel,
   input  logic       partner_open,
   input  logic       ext,
   input  logic       pair_comb,
   output logic       val
);
   always_comb begin
      case (sel)
         VS_PARTNER: val = partner_open;
         VS_ANY:     val = partner_open | ext;
         VS_BOTH:    val = partner_open & ext;
         VS_PAIR:    val = pair_comb;
         VS_EXT:     val = ext;
         default:    val = 1'b0;
      endcase
   end
endmodule

// File: rtl/pct_pair_comb.sv
module pct_pair_comb
   import pct_pkg::*;
(
   input  logic [2:0] sel,
   input  logic       open_even,
   input  logic       open_odd,
   output logic       comb
);
   always_comb begin
      case (sel)
         PC_AND:  comb = open_even & open_odd;
         PC_OR:   comb = open_even | open_odd;
         PC_EVEN: comb = open_even;
         PC_ODD:  comb = open_odd;
         default: comb = 1'b0;
      endcase
   end
endmodule

// File: rtl/pair_coinc_trigger.sv
module pair_coinc_trigger
   import pct_pkg::*;
#(
   parameter int WIDTH_W    = 10,
   parameter bit TRIG_PULSE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               raw_even,
   input  logic               raw_odd,
   input  logic               ext_valid,
   input  logic [1:0]         cfg_mode_even,
   input  logic [1:0]         cfg_mode_odd,
   input  logic               cfg_self_off_even,
   input  logic               cfg_self_off_odd,
   input  logic [WIDTH_W-1:0] cfg_width_even,
   input  logic [WIDTH_W-1:0] cfg_width_odd,
   input  logic [2:0]         cfg_val_even,
   input  logic [2:0]         cfg_val_odd,
   input  logic [2:0]         cfg_pair_mode,
   output logic               acc_even,
   output logic               acc_odd,
   output logic               trig_out
);
   localparam int CH_BITS  = ch_bits(WIDTH_W);
   localparam int CFG_BITS = 2 * CH_BITS + SEL_BITS;
   localparam int N_CH     = 2;

   if (WIDTH_W < 1 || WIDTH_W > 16) begin : g_bad_width
      $error("pair_coinc_trigger: WIDTH_W must be 1..16");
   end

   logic                raw_v   [N_CH];
   logic [CH_BITS-1:0]  ch_in   [N_CH];
   logic [CH_BITS-1:0]  ch_eff  [N_CH];
   logic [1:0]          eff_mode  [N_CH];
   logic                eff_off   [N_CH];
   logic [2:0]          eff_val   [N_CH];
   logic [WIDTH_W-1:0]  eff_width [N_CH];
   logic [2:0]          eff_pair;
   logic [CFG_BITS-1:0] cfg_in_bus;
   logic [CFG_BITS-1:0] cfg_eff_bus;
   logic [WIDTH_W-1:0]  cnt_v  [N_CH];
   logic                hit_v  [N_CH];
   logic                open_v [N_CH];
   logic                qual_v [N_CH];
   logic                val_v  [N_CH];
   logic                idle;
   logic                comb;
   logic                acc_q [N_CH];

   assign raw_v[0] = raw_even;
   assign raw_v[1] = raw_odd;
   assign ch_in[0] = {cfg_mode_even, cfg_self_off_even, cfg_val_even, cfg_width_even};
   assign ch_in[1] = {cfg_mode_odd,  cfg_self_off_odd,  cfg_val_odd,  cfg_width_odd};
   assign cfg_in_bus = {cfg_pair_mode, ch_in[1], ch_in[0]};

   // idle: no window open from an earlier hit
   assign idle = (cnt_v[0] == '0) && (cnt_v[1] == '0);

   pct_cfg_hold #(.CFG_BITS(CFG_BITS)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .idle    (idle),
      .cfg_in  (cfg_in_bus),
      .cfg_eff (cfg_eff_bus)
   );

   assign eff_pair = cfg_eff_bus[CFG_BITS-1 -: SEL_BITS];

   pct_pair_comb u_comb (
      .sel       (eff_pair),
      .open_even (open_v[0]),
      .open_odd  (open_v[1]),
      .comb      (comb)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      assign ch_eff[i]    = cfg_eff_bus[i*CH_BITS +: CH_BITS];
      assign eff_mode[i]  = ch_eff[i][CH_BITS-1 -: MODE_BITS];
      assign eff_off[i]   = ch_eff[i][CH_BITS-1-MODE_BITS];
      assign eff_val[i]   = ch_eff[i][WIDTH_W +: SEL_BITS];
      assign eff_width[i] = ch_eff[i][WIDTH_W-1:0];

      pct_val_sel u_val (
         .sel          (eff_val[i]),
         .partner_open (open_v[N_CH-1-i]),
         .ext          (ext_valid),
         .pair_comb    (comb),
         .val          (val_v[i])
      );

      pct_window #(.WIDTH_W(WIDTH_W)) u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw      (raw_v[i]),
         .self_off (eff_off[i]),
         .mode     (eff_mode[i]),
         .width    (eff_width[i]),
         .val      (val_v[i]),
         .hit      (hit_v[i]),
         .open_now (open_v[i]),
         .qual     (qual_v[i]),
         .cnt      (cnt_v[i])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) acc_q[i] <= 1'b0;
         else        acc_q[i] <= qual_v[i];
      end
   end

   assign acc_even = acc_q[0];
   assign acc_odd  = acc_q[1];

   if (TRIG_PULSE) begin : g_trig_edge
      logic comb_d;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            comb_d   <= 1'b0;
            trig_out <= 1'b0;
         end else begin
            comb_d   <= comb;
            trig_out <= comb & ~comb_d;
         end
      end
   end else begin : g_trig_level
      always_ff @(posedge clk) begin
         if (!rst_n) trig_out <= 1'b0;
         else        trig_out <= comb;
      end
   end
endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
   parameter int WIDTH_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               raw_even,
   input logic               raw_odd,
   input logic               acc_even,
   input logic               acc_odd,
   input logic               trig_out,
   input logic               idle,
   input logic [WIDTH_W-1:0] cnt_e,
   input logic [WIDTH_W-1:0] cnt_o,
   input logic [WIDTH_W-1:0] eff_width_e,
   input logic [WIDTH_W-1:0] eff_width_o,
   input logic               eff_off_e,
   input logic [1:0]         eff_mode_e,
   input logic [1:0]         eff_mode_o
);
   logic hit_e;
   assign hit_e = raw_even && !eff_off_e;

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!acc_even && !acc_odd && !trig_out && cnt_e == '0 && cnt_o == '0));

   assert_window_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_e |=> (cnt_e == $past(eff_width_e)));

   assert_window_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_e && cnt_e != '0) |=> (cnt_e == $past(cnt_e) - 1'b1));

   assert_self_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_even && eff_off_e && cnt_e == '0) |=> (cnt_e == '0));

   assert_normal_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_e && eff_mode_e == 2'b00) |=> acc_even);

   assert_accept_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_odd |-> ($past(raw_odd) || $past(cnt_o != '0)));

   assert_trig_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |=> !trig_out);

   assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> ($stable(eff_width_e) && $stable(eff_width_o) && $stable(eff_mode_e) && $stable(eff_mode_o)));

   assert_reserved_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eff_mode_o[1] |=> !acc_odd);
endmodule

bind pair_coinc_trigger pct_checker #(.WIDTH_W(WIDTH_W)) u_pct_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .raw_even    (raw_even),
   .raw_odd     (raw_odd),
   .acc_even    (acc_even),
   .acc_odd     (acc_odd),
   .trig_out    (trig_out),
   .idle        (idle),
   .cnt_e       (cnt_v[0]),
   .cnt_o       (cnt_v[1]),
   .eff_width_e (eff_width[0]),
   .eff_width_o (eff_width[1]),
   .eff_off_e   (eff_off[0]),
   .eff_mode_e  (eff_mode[0]),
   .eff_mode_o  (eff_mode[1])
);

// File: tb/pair_coinc_trigger_test.sv
`timescale 1ns/1ps
module pair_coinc_trigger_test;
   localparam int WW = 10;
   localparam int NONE = -1000000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic raw_even = 1'b0, raw_odd = 1'b0, ext_valid = 1'b0;
   logic [1:0] cfg_mode_even = 2'b00, cfg_mode_odd = 2'b00;
   logic cfg_self_off_even = 1'b0, cfg_self_off_odd = 1'b0;
   logic [WW-1:0] cfg_width_even = '0, cfg_width_odd = '0;
   logic [2:0] cfg_val_even = 3'b000, cfg_val_odd = 3'b000, cfg_pair_mode = 3'b000;
   logic acc_even, acc_odd, trig_out;

   always #10 clk = ~clk;

   pair_coinc_trigger #(.WIDTH_W(WW)) uut (
      .clk(clk), .rst_n(rst_n), .raw_even(raw_even), .raw_odd(raw_odd), .ext_valid(ext_valid),
      .cfg_mode_even(cfg_mode_even), .cfg_mode_odd(cfg_mode_odd),
      .cfg_self_off_even(cfg_self_off_even), .cfg_self_off_odd(cfg_self_off_odd),
      .cfg_width_even(cfg_width_even), .cfg_width_odd(cfg_width_odd),
      .cfg_val_even(cfg_val_even), .cfg_val_odd(cfg_val_odd), .cfg_pair_mode(cfg_pair_mode),
      .acc_even(acc_even), .acc_odd(acc_odd), .trig_out(trig_out));

   // staged configuration, applied at the next driving edge
   int st_mode[2], st_off[2], st_w[2], st_val[2], st_pair;
   // model state
   int m_mode[2], m_off[2], m_w[2], m_val[2], m_pair;
   int last_hit[2], hit_w[2];
   bit done_acc[2];
   bit comb_prev;
   bit exp_acc[2], exp_trig;
   int tcyc;
   int n_chk = 0, n_fail = 0;
   string cur_tag = "R1";
   bit finished = 1'b0;

   task automatic chk(input logic act, input logic exp, input string nm);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s cycle %0d: actual %b expected %b", cur_tag, nm, tcyc, act, exp);
      end
   endtask

   function automatic bit win_live(input int x);
      return (last_hit[x] < tcyc) && (tcyc - last_hit[x] <= hit_w[x]);
   endfunction

   task automatic model(input bit re, input bit ro, input bit ev);
      bit raw[2], hit[2], opn[2], val[2], armed[2], q[2], cmb, po;
      raw[0] = re; raw[1] = ro;
      if (!win_live(0) && !win_live(1)) begin
         m_mode = st_mode; m_off = st_off; m_w = st_w; m_val = st_val; m_pair = st_pair;
      end
      for (int x = 0; x < 2; x++) begin
         hit[x] = raw[x] && (m_off[x] == 0);
         opn[x] = hit[x] || win_live(x);
      end
      case (m_pair)
         0: cmb = opn[0] && opn[1];
         1: cmb = opn[0] || opn[1];
         5: cmb = opn[0];
         6: cmb = opn[1];
         default: cmb = 1'b0;
      endcase
      for (int x = 0; x < 2; x++) begin
         po = opn[1-x];
         case (m_val[x])
            0: val[x] = po;
            1: val[x] = po || ev;
            2: val[x] = po && ev;
            3: val[x] = cmb;
            5: val[x] = ev;
            default: val[x] = 1'b0;
         endcase
         armed[x] = hit[x] || (!done_acc[x] && win_live(x));
         if (m_mode[x] == 0)      q[x] = hit[x];
         else if (m_mode[x] == 1) q[x] = armed[x] && val[x];
         else                     q[x] = 1'b0;
      end
      for (int x = 0; x < 2; x++) begin
         if (hit[x]) begin
            last_hit[x] = tcyc; hit_w[x] = m_w[x]; done_acc[x] = q[x];
         end else if (q[x]) done_acc[x] = 1'b1;
         exp_acc[x] = q[x];
      end
      exp_trig = cmb && !comb_prev;
      comb_prev = cmb;
      tcyc++;
   endtask

   task automatic cyc(input bit re, input bit ro, input bit ev);
      @(negedge clk);
      chk(acc_even, exp_acc[0], "acc_even");
      chk(acc_odd,  exp_acc[1], "acc_odd");
      chk(trig_out, exp_trig,   "trig_out");
      raw_even = re; raw_odd = ro; ext_valid = ev;
      cfg_mode_even = st_mode[0][1:0]; cfg_mode_odd = st_mode[1][1:0];
      cfg_self_off_even = st_off[0][0]; cfg_self_off_odd = st_off[1][0];
      cfg_width_even = st_w[0][WW-1:0]; cfg_width_odd = st_w[1][WW-1:0];
      cfg_val_even = st_val[0][2:0]; cfg_val_odd = st_val[1][2:0];
      cfg_pair_mode = st_pair[2:0];
      model(re, ro, ev);
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0);
   endtask

   task automatic setup(input int me, input int mo, input int w, input int ve, input int vo, input int pm);
      st_mode[0] = me; st_mode[1] = mo; st_w[0] = w; st_w[1] = w;
      st_val[0] = ve; st_val[1] = vo; st_pair = pm; st_off[0] = 0; st_off[1] = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int x = 0; x < 2; x++) begin
         last_hit[x] = NONE; hit_w[x] = 0; done_acc[x] = 1'b1; exp_acc[x] = 1'b0;
         m_mode[x] = 0; m_off[x] = 0; m_w[x] = 0; m_val[x] = 0;
      end
      m_pair = 0; exp_trig = 1'b0; comb_prev = 1'b0; tcyc = 0;
      setup(0, 0, 0, 0, 0, 0);
      // R1: reset state
      cur_tag = "R1";
      repeat (3) begin
         @(negedge clk);
         chk(acc_even, 1'b0, "acc_even"); chk(acc_odd, 1'b0, "acc_odd"); chk(trig_out, 1'b0, "trig_out");
      end
      raw_even = 1'b1; raw_odd = 1'b1;
      @(negedge clk);
      chk(acc_even, 1'b0, "acc_even in reset");
      raw_even = 1'b0; raw_odd = 1'b0;
      rst_n = 1'b1;
      quiet(3);

      // R4: independent mode, OR combination
      cur_tag = "R4";
      setup(0, 0, 4, 0, 0, 1);
      cyc(1,0,0); cyc(1,0,0); cyc(0,1,0); quiet(2); cyc(1,1,0); quiet(8);

      // R2: window edge and restart (odd validates on even window)
      cur_tag = "R2";
      setup(0, 1, 4, 0, 0, 5);
      cyc(1,0,0); quiet(3); cyc(0,1,0); quiet(10);          // k=W: accepted
      cyc(1,0,0); quiet(4); cyc(0,1,0); quiet(10);          // k=W+1: rejected
      cyc(1,0,0); quiet(2); cyc(1,0,0); quiet(3); cyc(0,1,0); quiet(10); // restart reaches
      cyc(1,0,0); quiet(2); cyc(1,0,0); quiet(4); cyc(0,1,0); quiet(12); // not additive
      st_w[0] = 125;
      cyc(1,0,0); quiet(124); cyc(0,1,0); quiet(130);

      // R3: self-trigger off
      cur_tag = "R3";
      setup(0, 1, 4, 0, 0, 1); st_off[0] = 1;
      cyc(1,0,0); cyc(0,1,0); quiet(8); cyc(1,1,0); quiet(8);

      // R5: coincidence, partner fires later inside the window
      cur_tag = "R5";
      setup(0, 1, 5, 0, 0, 0);
      cyc(0,1,0); quiet(1); cyc(1,0,0); quiet(10);
      cyc(0,1,0); quiet(10);
      cyc(0,1,0); cyc(0,1,0); quiet(2); cyc(1,0,0); quiet(10);

      // R6: validation sources
      cur_tag = "R6";
      setup(0, 1, 3, 0, 5, 1);
      cyc(0,1,0); cyc(0,0,1); quiet(6); cyc(0,1,0); quiet(6);
      st_val[1] = 1; cyc(0,1,0); quiet(1); cyc(0,0,1); quiet(6);
      st_val[1] = 2; cyc(1,0,0); cyc(0,1,0); quiet(1); cyc(0,0,1); quiet(6);
      cyc(1,1,0); quiet(6);
      st_val[1] = 3; st_pair = 0; cyc(0,1,0); quiet(1); cyc(1,0,0); quiet(6);
      st_pair = 6; cyc(0,1,0); quiet(6);

      // R7: combination codes and trig_out pulse
      cur_tag = "R7";
      setup(0, 0, 3, 0, 0, 0);
      cyc(1,0,0); quiet(6); cyc(1,0,0); cyc(0,1,0); quiet(6);
      st_pair = 1; cyc(1,0,0); cyc(0,1,0); quiet(6);
      st_pair = 5; cyc(0,1,0); quiet(5); cyc(1,0,0); quiet(6);
      st_pair = 6; cyc(0,1,0); quiet(6);

      // R8: both coincidence, AND combination
      cur_tag = "R8";
      setup(1, 1, 4, 0, 0, 0);
      cyc(1,0,0); quiet(3); cyc(0,1,0); quiet(10);
      cyc(1,0,0); quiet(4); cyc(0,1,0); quiet(10);
      cyc(1,1,0); quiet(10);

      // R9: configuration held while a window is open
      cur_tag = "R9";
      setup(0, 1, 6, 0, 0, 1);
      cyc(1,0,0);
      st_mode[1] = 2; st_w[0] = 1; st_val[1] = 7;
      cyc(0,0,0); cyc(0,1,0); quiet(2); cyc(1,0,0); quiet(5); cyc(0,1,0); quiet(12);

      // R10: reserved codes, new config now in force after idle
      cur_tag = "R10";
      cyc(1,0,0); cyc(0,1,0); quiet(6);
      setup(3, 2, 4, 7, 7, 7);
      cyc(1,1,0); quiet(2); cyc(1,1,1); quiet(6);
      setup(1, 1, 4, 7, 4, 2);
      cyc(1,1,1); quiet(8);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule